// File: doc/BRIEF.md
# Expansion Slot Presence Probe

This block finds out, at startup, which of the twelve card positions on an I/O expansion bus hold a card, and which option code each card reports. A start pulse launches one pass. The pass walks the positions in rising order. For each position it first writes a zero byte to the card's command location. It then fetches a two-byte identifier, high byte first. Every access goes out through a simple single-transaction bus master port. An access that sees no acknowledge within a set number of cycles ends with a timeout, and that position is then recorded as empty.

The results sit in a small table: one presence bit and one 16-bit code per position, plus a running total of devices found. Position 0 is the system board. It is always marked present, carries a fixed code and is included in the total. A done flag tells the surrounding startup logic that the table is complete.

Top module: `expansion_probe`

## Requirements
- R1: After reset the bus request, busy and done outputs are low, only position 0 is marked present, all other codes read 0 and the device total is 1.
- R2: A start pulse while idle launches a pass, with busy going high; a start pulse during a pass is ignored and neither restarts nor disturbs it.
- R3: Positions 1 to 12 are probed strictly in ascending order, and the base address of position n is n × 0x200000 (position 12 at 0x1800000).
- R4: The first access to each position is a write (we=1) of data 0x00 to base + 5.
- R5: After the write is acknowledged, a read of base + 0 supplies the code's high byte and a read of base + 1 supplies its low byte; the stored code is {high, low}.
- R6: Only one access is outstanding: once raised, the request stays high with a stable address until an acknowledge or a timeout ends it.
- R7: An access times out when no acknowledge has been seen by its 16th request cycle (TIMEOUT_CYCLES); an acknowledge arriving in that 16th cycle is still accepted.
- R8: A timeout on the write or on either read marks that position absent with code 0, leaves the total unchanged, and the pass moves on to the next position.
- R9: Position 0 is always present with code BOARD_CODE (default 0x0001), and the device total always equals the number of present positions, from 1 up to 13.
- R10: Done rises once position 12 has been handled, busy then falls, and done stays high until the next accepted start; that start clears the table back to its reset contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse for a pass |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | Last pass completed; table valid |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W (25) | Access byte address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Access acknowledge, one cycle |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |
| slot_present_o | output | NUM_SLOTS+1 (13) | Presence bit per position, bit n for position n |
| slot_code_o | output | 16×(NUM_SLOTS+1) (208) | Option codes, position n at bits [16n+15:16n] |
| dev_count_o | output | 4 | Number of present positions |

## Verification
An acknowledge and the access timer's expiry can fall in the same cycle. When they do, the acknowledge must win. The bench drives this case with a responder that holds off the write acknowledge of one card until exactly the 16th request cycle, so the card must then be found. A second card gets its acknowledge one cycle later, so it must be marked absent. Both are judged at the ports, from the presence bit, the code and the total.

// File: rtl/probe_pkg.sv
// probe_pkg: shared sequencer state encoding and per-card register offsets
// for the expansion slot probe. Assumes byte addressing on the probe bus.
package probe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_CMD,
        ST_RD_HI,
        ST_RD_LO,
        ST_ADVANCE
    } probe_state_t;

    // Offsets inside one card's window; the access order depends on them.
    localparam int CMD_OFS   = 5;
    localparam int ID_HI_OFS = 0;
    localparam int ID_LO_OFS = 1;

endpackage

// File: rtl/bus_timer.sv
// bus_timer: counts the cycles of one outstanding access and flags expiry
// when the request has been up for TIMEOUT_CYCLES cycles with no acknowledge.
// Assumes the request stays high for the whole access and an acknowledge
// ends it. An acknowledge in the expiry cycle masks the expiry.
module bus_timer #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    logic [CW-1:0] wait_q;

    // Expiry is raised in the last permitted request cycle when no ack is seen.
    always_comb begin
        expire = req && !ack && (wait_q == CW'(TIMEOUT_CYCLES - 1));
    end

    // Cycle counter, restarted whenever an access ends or none is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (!req || ack || expire) begin
            wait_q <= '0;
        end else begin
            wait_q <= wait_q + CW'(1);
        end
    end

endmodule

// File: rtl/probe_seq.sv
// probe_seq: walks positions 1..NUM_SLOTS. For each one it issues the
// command write, then the high and low identifier reads, and hands
// successful identifiers to the table. Assumes one access at a time: the
// next access starts only after an acknowledge or an expiry.
module probe_seq
    import probe_pkg::*;
#(
    parameter int NUM_SLOTS   = 12,
    parameter int ADDR_W      = 25,
    parameter int SLOT_STRIDE = 32'h0020_0000,
    localparam int SLOT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    input  logic              expire,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              busy,
    output logic              done,
    output logic              tbl_clear,
    output logic              tbl_wr,
    output logic [SLOT_W-1:0] tbl_slot,
    output logic [15:0]       tbl_code
);
    probe_state_t      state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [7:0]        hi_q;
    logic              done_q;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs;

    // Address of the current access: position base plus register offset.
    always_comb begin
        base = ADDR_W'(slot_q) * ADDR_W'(SLOT_STRIDE);
        unique case (state_q)
            ST_WR_CMD: ofs = ADDR_W'(CMD_OFS);
            ST_RD_HI:  ofs = ADDR_W'(ID_HI_OFS);
            ST_RD_LO:  ofs = ADDR_W'(ID_LO_OFS);
            default:   ofs = '0;
        endcase
        bus_addr = base + ofs;
    end

    // Bus and table control derived from the current step.
    always_comb begin
        bus_req   = (state_q == ST_WR_CMD) || (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
        bus_we    = (state_q == ST_WR_CMD);
        bus_wdata = 8'h00;
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        tbl_clear = (state_q == ST_IDLE) && start;
        tbl_wr    = (state_q == ST_RD_LO) && bus_ack;
        tbl_slot  = slot_q;
        tbl_code  = {hi_q, bus_rdata};
    end

    // Step sequencing across positions; the acknowledge has priority over expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            hi_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_WR_CMD;
                        slot_q  <= SLOT_W'(1);
                        done_q  <= 1'b0;
                    end
                end
                ST_WR_CMD: begin
                    if (bus_ack) begin
                        state_q <= ST_RD_HI;
                    end else if (expire) begin
                        state_q <= ST_ADVANCE;
                    end
                end
                ST_RD_HI: begin
                    if (bus_ack) begin
                        hi_q    <= bus_rdata;
                        state_q <= ST_RD_LO;
                    end else if (expire) begin
                        state_q <= ST_ADVANCE;
                    end
                end
                ST_RD_LO: begin
                    if (bus_ack || expire) begin
                        state_q <= ST_ADVANCE;
                    end
                end
                ST_ADVANCE: begin
                    if (slot_q == SLOT_W'(NUM_SLOTS)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        slot_q  <= slot_q + SLOT_W'(1);
                        state_q <= ST_WR_CMD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/slot_table.sv
// slot_table: per-position presence bits and option codes, plus the device
// total. Position 0 is tied to the system board. Assumes clear and write
// never occur in the same cycle.
module slot_table #(
    parameter int          NUM_SLOTS  = 12,
    parameter logic [15:0] BOARD_CODE = 16'h0001,
    localparam int SLOT_W = $clog2(NUM_SLOTS + 1),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        wr,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [15:0]                 wr_code,
    output logic [NUM_SLOTS:0]          present,
    output logic [16*(NUM_SLOTS+1)-1:0] codes,
    output logic [CNT_W-1:0]            count
);
    // Position 0: the system board, fixed.
    assign present[0]  = 1'b1;
    assign codes[15:0] = BOARD_CODE;

    // One entry per probed position.
    for (genvar i = 1; i <= NUM_SLOTS; i++) begin : g_entry
        logic        pres_q;
        logic [15:0] code_q;

        // Entry capture: cleared on reset or a new pass, filled on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                pres_q <= 1'b0;
                code_q <= '0;
            end else if (wr && (wr_slot == SLOT_W'(i))) begin
                pres_q <= 1'b1;
                code_q <= wr_code;
            end
        end

        assign present[i]         = pres_q;
        assign codes[16*i +: 16]  = code_q;
    end

    // Device total: starts at 1 for the board, grows on each hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= CNT_W'(1);
        end else if (wr) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/expansion_probe.sv
// expansion_probe: top of the expansion slot presence probe. Joins the
// sequencer, the access timer and the result table. Assumes a single-cycle
// acknowledge from the bus with read data valid in that cycle.
module expansion_probe #(
    parameter int          NUM_SLOTS      = 12,
    parameter int          ADDR_W         = 25,
    parameter int          SLOT_STRIDE    = 32'h0020_0000,
    parameter int          TIMEOUT_CYCLES = 16,
    parameter logic [15:0] BOARD_CODE     = 16'h0001,
    localparam int SLOT_W = $clog2(NUM_SLOTS + 1),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        bus_req_o,
    output logic                        bus_we_o,
    output logic [ADDR_W-1:0]           bus_addr_o,
    output logic [7:0]                  bus_wdata_o,
    input  logic                        bus_ack_i,
    input  logic [7:0]                  bus_rdata_i,
    output logic [NUM_SLOTS:0]          slot_present_o,
    output logic [16*(NUM_SLOTS+1)-1:0] slot_code_o,
    output logic [CNT_W-1:0]            dev_count_o
);
    logic              expire;
    logic              tbl_clear;
    logic              tbl_wr;
    logic [SLOT_W-1:0] tbl_slot;
    logic [15:0]       tbl_code;

    bus_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req_o),
        .ack    (bus_ack_i),
        .expire (expire)
    );

    probe_seq #(
        .NUM_SLOTS  (NUM_SLOTS),
        .ADDR_W     (ADDR_W),
        .SLOT_STRIDE(SLOT_STRIDE)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .bus_ack   (bus_ack_i),
        .bus_rdata (bus_rdata_i),
        .expire    (expire),
        .bus_req   (bus_req_o),
        .bus_we    (bus_we_o),
        .bus_addr  (bus_addr_o),
        .bus_wdata (bus_wdata_o),
        .busy      (busy_o),
        .done      (done_o),
        .tbl_clear (tbl_clear),
        .tbl_wr    (tbl_wr),
        .tbl_slot  (tbl_slot),
        .tbl_code  (tbl_code)
    );

    slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .BOARD_CODE(BOARD_CODE)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tbl_clear),
        .wr      (tbl_wr),
        .wr_slot (tbl_slot),
        .wr_code (tbl_code),
        .present (slot_present_o),
        .codes   (slot_code_o),
        .count   (dev_count_o)
    );

endmodule

// File: rtl/expansion_probe_chk.sv
// expansion_probe_chk: protocol and table properties of the probe, bound to
// the top. Keeps its own request-age counter to judge the timeout window.
module expansion_probe_chk #(
    parameter int NUM_SLOTS      = 12,
    parameter int ADDR_W         = 25,
    parameter int SLOT_STRIDE    = 32'h0020_0000,
    parameter int TIMEOUT_CYCLES = 16,
    localparam int CNT_W = $clog2(NUM_SLOTS + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack,
    input logic              expire,
    input logic [NUM_SLOTS:0] present,
    input logic [CNT_W-1:0]  count
);
    int age_q;

    // Age of the current access in request cycles, tracked independently.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_req || bus_ack || expire) begin
            age_q <= 0;
        end else begin
            age_q <= age_q + 1;
        end
    end

    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !expire |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    a_r7_expire_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> bus_req && !bus_ack && (age_q == TIMEOUT_CYCLES - 1));

    a_r7_expire_when_due: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && (age_q == TIMEOUT_CYCLES - 1) |-> expire);

    a_r4_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> ((bus_addr % ADDR_W'(SLOT_STRIDE)) == ADDR_W'(5)) && (bus_wdata == 8'h00));

    a_r5_read_target: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> ((bus_addr % ADDR_W'(SLOT_STRIDE)) <= ADDR_W'(1)));

    a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr >= ADDR_W'(SLOT_STRIDE)) && (bus_addr < ADDR_W'((NUM_SLOTS + 1) * SLOT_STRIDE)));

    a_r9_board_present: assert property (@(posedge clk) disable iff (!rst_n)
        present[0]);

    a_r9_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(present) == int'(count));

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !bus_req);

endmodule

bind expansion_probe expansion_probe_chk #(
    .NUM_SLOTS     (NUM_SLOTS),
    .ADDR_W        (ADDR_W),
    .SLOT_STRIDE   (SLOT_STRIDE),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_o),
    .done     (done_o),
    .bus_req  (bus_req_o),
    .bus_we   (bus_we_o),
    .bus_addr (bus_addr_o),
    .bus_wdata(bus_wdata_o),
    .bus_ack  (bus_ack_i),
    .expire   (expire),
    .present  (slot_present_o),
    .count    (dev_count_o)
);

// File: tb/expansion_probe_tb_top.sv
// Bench for expansion_probe: a card responder model driven by a per-position
// table, one table-walking pass, then directed runs for corner cases.
module expansion_probe_tb_top;
    localparam int NS     = 12;
    localparam int AW     = 25;
    localparam int STRIDE = 32'h0020_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              busy_o, done_o, bus_req_o, bus_we_o;
    logic [AW-1:0]     bus_addr_o;
    logic [7:0]        bus_wdata_o;
    logic              bus_ack_i = 1'b0;
    logic [7:0]        bus_rdata_i = 8'h00;
    logic [NS:0]       slot_present_o;
    logic [16*(NS+1)-1:0] slot_code_o;
    logic [3:0]        dev_count_o;

    expansion_probe dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
        .slot_present_o(slot_present_o), .slot_code_o(slot_code_o),
        .dev_count_o(dev_count_o)
    );

    always #5 clk = ~clk;

    // Per-position vector: {mode[2:0], write latency[4:0], code[15:0]}.
    // mode 0 answers all; 1 silent on write; 2 silent on high read; 3 silent on low read.
    localparam logic [23:0] VEC [0:11] = '{
        {3'd0, 5'd0,  16'h0003},
        {3'd1, 5'd0,  16'h2222},
        {3'd0, 5'd15, 16'h0100},
        {3'd0, 5'd16, 16'hBEEF},
        {3'd2, 5'd0,  16'h5555},
        {3'd0, 5'd3,  16'hFFFF},
        {3'd3, 5'd0,  16'h7777},
        {3'd0, 5'd1,  16'h8001},
        {3'd1, 5'd2,  16'h9999},
        {3'd0, 5'd7,  16'h1234},
        {3'd2, 5'd1,  16'hABCD},
        {3'd0, 5'd2,  16'hA5C3}
    };

    int          cfg_mode [0:15];
    int          cfg_lat  [0:15];
    logic [15:0] cfg_code [0:15];

    int checks = 0;
    int errors = 0;
    int pat_err = 0;
    int last_slot = 0;
    int last_ofs = 1;
    int wait_cnt = 0;
    logic         prev_req = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Card responder and access-order tracker, acting on the falling edge.
    always @(negedge clk) begin
        int sl, of;
        bit silent;
        int lim;
        sl = int'(bus_addr_o / AW'(STRIDE));
        of = int'(bus_addr_o % AW'(STRIDE));
        if (start_i && !busy_o) begin
            last_slot = 0;
            last_ofs = 1;
        end
        if (bus_req_o && (!prev_req || bus_addr_o != prev_addr)) begin
            if (of == 5) begin
                if (sl != last_slot + 1 || !bus_we_o || bus_wdata_o != 8'h00) pat_err++;
            end else if (of == 0) begin
                if (sl != last_slot || last_ofs != 5 || bus_we_o) pat_err++;
            end else if (of == 1) begin
                if (sl != last_slot || last_ofs != 0 || bus_we_o) pat_err++;
            end else begin
                pat_err++;
            end
            last_slot = sl;
            last_ofs = of;
        end
        prev_req = bus_req_o;
        prev_addr = bus_addr_o;

        if (!rst_n || !bus_req_o || bus_ack_i) begin
            bus_ack_i <= 1'b0;
            wait_cnt = 0;
        end else if (sl >= 1 && sl <= NS) begin
            silent = (cfg_mode[sl] == 1 && bus_we_o) ||
                     (cfg_mode[sl] == 2 && !bus_we_o && of == 0) ||
                     (cfg_mode[sl] == 3 && !bus_we_o && of == 1);
            lim = bus_we_o ? cfg_lat[sl] : 1;
            if (!silent && wait_cnt == lim) begin
                bus_ack_i <= 1'b1;
                bus_rdata_i <= (of == 0) ? cfg_code[sl][15:8] : cfg_code[sl][7:0];
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        @(posedge clk); #2 start_i = 1'b1;
        @(posedge clk); #2 start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done_o) break;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            cfg_mode[i] = 0; cfg_lat[i] = 0; cfg_code[i] = '0;
        end
        tick(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o, "R1", "busy/done after reset", {busy_o, done_o}, 0);
        check(!bus_req_o, "R1", "request after reset", bus_req_o, 0);
        check(slot_present_o == 13'h0001, "R1", "presence after reset", slot_present_o, 1);
        check(dev_count_o == 4'd1, "R1", "total after reset", dev_count_o, 1);
        check(slot_code_o[16*NS+15:16] == '0, "R1", "codes after reset", slot_code_o[31:16], 0);
        check(slot_code_o[15:0] == 16'h0001, "R9", "board code", slot_code_o[15:0], 1);

        // Table-driven pass; position n uses VEC[n-1].
        for (int s = 1; s <= NS; s++) begin
            cfg_mode[s] = int'(VEC[s-1][23:21]);
            cfg_lat[s]  = int'(VEC[s-1][20:16]);
            cfg_code[s] = VEC[s-1][15:0];
        end
        pat_err = 0;
        pulse_start();
        check(busy_o, "R2", "busy after start", busy_o, 1);
        tick(30);
        start_i = 1'b1; tick(1); start_i = 1'b0;   // R2: ignored mid-pass
        wait_done();
        for (int s = 1; s <= NS; s++) begin
            bit exp_p;
            logic [15:0] exp_c;
            exp_p = (cfg_mode[s] == 0) && (cfg_lat[s] <= 15);
            exp_c = exp_p ? cfg_code[s] : 16'h0000;
            // R5 / R7 / R8 per position
            check(slot_present_o[s] == exp_p, "R8", $sformatf("presence of position %0d", s),
                  slot_present_o[s], exp_p);
            check(slot_code_o[16*s +: 16] == exp_c, "R5", $sformatf("code of position %0d", s),
                  slot_code_o[16*s +: 16], exp_c);
        end
        check(slot_present_o[3] == 1'b1, "R7", "ack in expiry cycle accepted", slot_present_o[3], 1);
        check(slot_present_o[4] == 1'b0, "R7", "ack one cycle late rejected", slot_present_o[4], 0);
        check(dev_count_o == 4'd7, "R9", "total after mixed pass", dev_count_o, 7);
        check(pat_err == 0, "R4", "access pattern errors", pat_err, 0);
        check(last_slot == NS, "R3", "last position probed", last_slot, NS);
        check(done_o && !busy_o, "R10", "done/busy at end", {done_o, busy_o}, 2);
        tick(10);
        check(done_o, "R10", "done held while idle", done_o, 1);

        // All positions empty: check clearing, total, and expiry timing.
        for (int s = 1; s <= NS; s++) cfg_mode[s] = 1;
        pat_err = 0;
        pulse_start();
        check(!done_o, "R10", "done cleared by start", done_o, 0);
        check(slot_present_o == 13'h0001, "R10", "table cleared by start", slot_present_o, 1);
        begin
            int hi_cycles;
            hi_cycles = 0;
            @(negedge clk);
            while (bus_req_o) begin
                hi_cycles++;
                @(negedge clk);
            end
            check(hi_cycles == 15 || hi_cycles == 16, "R7", "request cycles before expiry",
                  hi_cycles + 1, 16);
        end
        wait_done();
        check(slot_present_o == 13'h0001, "R8", "empty bus presence", slot_present_o, 1);
        check(dev_count_o == 4'd1, "R9", "empty bus total", dev_count_o, 1);
        check(pat_err == 0 && last_slot == NS, "R3", "empty bus order", pat_err, 0);

        // All positions populated: maximum total.
        for (int s = 1; s <= NS; s++) begin
            cfg_mode[s] = 0; cfg_lat[s] = 0; cfg_code[s] = 16'(s * 16'h1111);
        end
        pat_err = 0;
        pulse_start();
        wait_done();
        check(slot_present_o == 13'h1FFF, "R9", "full bus presence", slot_present_o, 16'h1FFF);
        check(dev_count_o == 4'd13, "R9", "full bus total", dev_count_o, 13);
        check(slot_code_o[16*NS +: 16] == 16'hCCCC, "R6", "last position code", slot_code_o[16*NS +: 16], 16'hCCCC);
        check(pat_err == 0, "R6", "full bus access pattern", pat_err, 0);

        report();
    end

endmodule